// File: doc/BRIEF.md
# Write Strobe Protocol Monitor

A passive monitor that sits beside a write path on a 32-bit AXI-style bus and watches the write-address and write-data channels. Each accepted write command is recorded in a small in-order queue. Each completed data beat is matched against the oldest open command. The monitor works out which byte lanes the beat may touch from the command's start offset, size and burst type. It then compares that lane set with the byte-enable mask that was observed on the beat.

The monitor drives no bus signal. When it finds misuse it raises a one-cycle error pulse together with a code that names the kind of violation. The checks cover a strobe bit outside the permitted lanes, a mask or data that changes while the beat is waiting, a misplaced or missing last flag, and an overflow of the holding buffer used for beats that arrive before their command. Sparse masks and empty masks inside the permitted lanes are accepted.

Top module: `wstrb_checker`

## Requirements
- R1: A beat whose mask sets any lane outside the permitted set raises error code 1. For offset o and size s (bytes b = 2^s, capped at the bus width), the permitted lanes are o up to (o rounded down to a multiple of b) + b - 1.
- R2: A mask with non-adjacent lanes inside the permitted set (for example 4'b1010 on a full-word beat) raises no error.
- R3: An all-zero mask raises no error and still counts as one beat toward the burst length.
- R4: The mask is evaluated only on cycles where valid and ready are both high. A mask driven while valid is low has no effect.
- R5: If valid was high and ready low in the previous cycle, and valid is still high but the mask or the data differs from that cycle, error code 2 is raised.
- R6: Burst type 2'b01 (incrementing) moves the next beat's offset to the end of the current aligned container, modulo the bus width. Burst type 2'b00 (fixed) repeats the first beat's lanes on every beat.
- R7: The last flag must be high exactly on beat number len (counting from 0). It being high on any other beat, or low on that beat, raises error code 3.
- R8: Commands are matched to data beats in acceptance order, and up to 4 commands may be waiting.
- R9: Beats that arrive with no command pending are held, up to 4 of them, and checked once a command arrives. A beat that completes while the buffer is full and no beat leaves in the same cycle raises error code 4 and is discarded.
- R10: After reset, err_o and err_code_o are 0. Each violation yields err_o high for one cycle, one cycle after detection. err_code_o is 0 whenever err_o is low. When violations coincide, the priority is code 4, then 2, then 1, then 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Address channel valid |
| aw_ready_i | input | 1 | Address channel ready |
| aw_addr_i | input | ADDR_W | Write start address |
| aw_size_i | input | 3 | Log2 of bytes per beat |
| aw_len_i | input | 8 | Beats minus one |
| aw_burst_i | input | 2 | Burst type: 00 fixed, 01 incrementing |
| w_valid_i | input | 1 | Data channel valid |
| w_ready_i | input | 1 | Data channel ready |
| w_data_i | input | DATA_W | Write data |
| w_strb_i | input | DATA_W/8 | Byte-enable mask |
| w_last_i | input | 1 | Last beat flag |
| err_o | output | 1 | Violation pulse |
| err_code_o | output | 3 | Violation code, 0 when idle |

## Verification
The bench builds the monitor with its defaults: a 32-bit bus with four lanes, a four-entry command queue and a four-entry beat buffer. With this size, a fifth early beat brings the buffer-overflow path within reach. Four commands queued before any data exercise the full depth of the in-order queue. Offsets 1, 2 and 3 with byte, halfword and word sizes cover the unaligned first beats, the lane advance of incrementing bursts and the repeated lanes of fixed bursts.

// File: rtl/wstrb_chk_pkg.sv
package wstrb_chk_pkg;
  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_LANE     = 3'd1,
    ERR_UNSTABLE = 3'd2,
    ERR_LAST     = 3'd3,
    ERR_OVERFLOW = 3'd4
  } err_code_e;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned SIZE_W = 3;
endpackage

// File: rtl/wstrb_fifo.sv
module wstrb_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign data_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= inc_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= inc_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/wstrb_lane_calc.sv
module wstrb_lane_calc #(
  parameter int unsigned STRB_W = 4,
  localparam int unsigned OFF_W = $clog2(STRB_W)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        size_i,
  input  logic              fixed_i,
  output logic [STRB_W-1:0] perm_o,
  output logic [OFF_W-1:0]  next_off_o
);
  localparam int unsigned PW = OFF_W + 1;

  logic [2:0]    size_c;
  logic [PW-1:0] bytes, off_x, aligned, lim;

  always_comb begin
    size_c  = (size_i > 3'(OFF_W)) ? 3'(OFF_W) : size_i;
    bytes   = PW'(1) << size_c;
    off_x   = {1'b0, off_i};
    aligned = off_x & ~(bytes - PW'(1));
    lim     = aligned + bytes;
    for (int n = 0; n < STRB_W; n++) begin
      perm_o[n] = (PW'(n) >= off_x) && (PW'(n) < lim);
    end
    next_off_o = fixed_i ? off_i : lim[OFF_W-1:0];
  end
endmodule

// File: rtl/wstrb_checker.sv
module wstrb_checker
  import wstrb_chk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CMD_DEPTH  = 4,
  parameter int unsigned BEAT_DEPTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  aw_valid_i,
  input  logic                  aw_ready_i,
  input  logic [ADDR_W-1:0]     aw_addr_i,
  input  logic [2:0]            aw_size_i,
  input  logic [7:0]            aw_len_i,
  input  logic [1:0]            aw_burst_i,
  input  logic                  w_valid_i,
  input  logic                  w_ready_i,
  input  logic [DATA_W-1:0]     w_data_i,
  input  logic [DATA_W/8-1:0]   w_strb_i,
  input  logic                  w_last_i,
  output logic                  err_o,
  output logic [2:0]            err_code_o
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(STRB_W);
  localparam int unsigned CMD_W  = OFF_W + SIZE_W + LEN_W + 2;
  localparam int unsigned BEAT_W = STRB_W + 1;

  // upper address bits do not affect lane selection
  logic unused_addr_hi;
  assign unused_addr_hi = ^aw_addr_i[ADDR_W-1:OFF_W];

  // command queue
  logic             aw_hs, cmd_push, cmd_pop, cmd_empty, cmd_full;
  logic [CMD_W-1:0] cmd_in, cmd_head;
  logic [OFF_W-1:0] cmd_off;
  logic [2:0]       cmd_size;
  logic [LEN_W-1:0] cmd_len;
  logic [1:0]       cmd_burst;

  assign aw_hs    = aw_valid_i && aw_ready_i;
  assign cmd_push = aw_hs && !cmd_full;
  assign cmd_in   = {aw_addr_i[OFF_W-1:0], aw_size_i, aw_len_i, aw_burst_i};
  assign {cmd_off, cmd_size, cmd_len, cmd_burst} = cmd_head;

  wstrb_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk_i, .rst_ni,
    .push_i (cmd_push),
    .pop_i  (cmd_pop),
    .data_i (cmd_in),
    .data_o (cmd_head),
    .empty_o(cmd_empty),
    .full_o (cmd_full)
  );

  // beat buffer
  logic              w_hs, beat_empty, beat_full, chk_fire, overflow;
  logic [BEAT_W-1:0] beat_head;
  logic [STRB_W-1:0] b_strb;
  logic              b_last;

  assign w_hs     = w_valid_i && w_ready_i;
  assign chk_fire = !beat_empty && !cmd_empty;
  assign overflow = w_hs && beat_full && !chk_fire;
  assign {b_strb, b_last} = beat_head;

  wstrb_fifo #(.WIDTH(BEAT_W), .DEPTH(BEAT_DEPTH)) u_beat_q (
    .clk_i, .rst_ni,
    .push_i (w_hs),
    .pop_i  (chk_fire),
    .data_i ({w_strb_i, w_last_i}),
    .data_o (beat_head),
    .empty_o(beat_empty),
    .full_o (beat_full)
  );

  // per-beat lane tracking
  logic [LEN_W-1:0]  beat_idx;
  logic [OFF_W-1:0]  cur_off, off_now, next_off;
  logic [STRB_W-1:0] perm_mask;
  logic              last_exp, lane_bad, last_bad;

  assign off_now = (beat_idx == '0) ? cmd_off : cur_off;

  wstrb_lane_calc #(.STRB_W(STRB_W)) u_lane (
    .off_i     (off_now),
    .size_i    (cmd_size),
    .fixed_i   (cmd_burst == BURST_FIXED),
    .perm_o    (perm_mask),
    .next_off_o(next_off)
  );

  assign last_exp = (beat_idx == cmd_len);
  assign cmd_pop  = chk_fire && last_exp;
  assign lane_bad = chk_fire && |(b_strb & ~perm_mask);
  assign last_bad = chk_fire && (b_last != last_exp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_idx <= '0;
      cur_off  <= '0;
    end else if (chk_fire) begin
      beat_idx <= last_exp ? '0 : beat_idx + 1'b1;
      cur_off  <= next_off;
    end
  end

  // hold stability
  logic              pend_q;
  logic [STRB_W-1:0] strb_q;
  logic [DATA_W-1:0] data_q;
  logic              unstable;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      strb_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= w_valid_i && !w_ready_i;
      strb_q <= w_strb_i;
      data_q <= w_data_i;
    end
  end

  assign unstable = w_valid_i && pend_q && ((w_strb_i != strb_q) || (w_data_i != data_q));

  // error report
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
    end else begin
      err_o <= overflow || unstable || lane_bad || last_bad;
      if (overflow)      err_code_o <= ERR_OVERFLOW;
      else if (unstable) err_code_o <= ERR_UNSTABLE;
      else if (lane_bad) err_code_o <= ERR_LANE;
      else if (last_bad) err_code_o <= ERR_LAST;
      else               err_code_o <= ERR_NONE;
    end
  end
endmodule

// File: rtl/wstrb_checker_sva.sv
module wstrb_checker_sva
  import wstrb_chk_pkg::*;
#(
  parameter int unsigned STRB_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              w_valid_i,
  input logic              w_ready_i,
  input logic [STRB_W-1:0] w_strb_i,
  input logic              err_o,
  input logic [2:0]        err_code_o,
  input logic              beat_full,
  input logic              chk_fire,
  input logic [STRB_W-1:0] b_strb,
  input logic              b_last,
  input logic              last_exp,
  input logic [STRB_W-1:0] perm_mask,
  input logic              overflow,
  input logic              unstable
);
  // R10
  a_r10_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> (err_code_o == ERR_NONE));

  a_r10_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o inside {ERR_LANE, ERR_UNSTABLE, ERR_LAST, ERR_OVERFLOW}));

  // R5
  a_r5_hold_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_i && $past(w_valid_i && !w_ready_i) && (w_strb_i != $past(w_strb_i)))
    |=> err_o);

  // R9
  a_r9_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_i && w_ready_i && beat_full && !chk_fire)
    |=> (err_o && err_code_o == ERR_OVERFLOW));

  // R1
  a_r1_lane_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_fire && |(b_strb & ~perm_mask) && !overflow && !unstable)
    |=> (err_o && err_code_o == ERR_LANE));

  // R7
  a_r7_last_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_fire && (b_last != last_exp)) |=> err_o);
endmodule

bind wstrb_checker wstrb_checker_sva #(.STRB_W(STRB_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .w_valid_i  (w_valid_i),
  .w_ready_i  (w_ready_i),
  .w_strb_i   (w_strb_i),
  .err_o      (err_o),
  .err_code_o (err_code_o),
  .beat_full  (beat_full),
  .chk_fire   (chk_fire),
  .b_strb     (b_strb),
  .b_last     (b_last),
  .last_exp   (last_exp),
  .perm_mask  (perm_mask),
  .overflow   (overflow),
  .unstable   (unstable)
);

// File: tb/wstrb_checker_test.sv
module wstrb_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_valid = 0, aw_ready = 0;
  logic [31:0] aw_addr = '0;
  logic [2:0]  aw_size = '0;
  logic [7:0]  aw_len = '0;
  logic [1:0]  aw_burst = '0;
  logic        w_valid = 0, w_ready = 0, w_last = 0;
  logic [31:0] w_data = '0;
  logic [3:0]  w_strb = '0;
  logic        err;
  logic [2:0]  err_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int data_seq = 0;

  logic [2:0] exp_code_q[$];
  string      exp_tag_q[$];

  always #4 clk = ~clk;

  wstrb_checker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_valid_i(aw_valid), .aw_ready_i(aw_ready), .aw_addr_i(aw_addr),
    .aw_size_i(aw_size), .aw_len_i(aw_len), .aw_burst_i(aw_burst),
    .w_valid_i(w_valid), .w_ready_i(w_ready), .w_data_i(w_data),
    .w_strb_i(w_strb), .w_last_i(w_last),
    .err_o(err), .err_code_o(err_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_err(input logic [2:0] code, input string tag);
    exp_code_q.push_back(code);
    exp_tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && err) begin
      if (exp_code_q.size() == 0) begin
        check(0, "unexpected error pulse", int'(err_code), 0);
      end else begin
        automatic logic [2:0] c = exp_code_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        check(err_code == c, t, int'(err_code), int'(c));
      end
    end
  end

  task automatic send_aw(input logic [1:0] off, input logic [2:0] size,
                         input logic [7:0] len, input logic [1:0] burst);
    aw_valid = 1; aw_ready = 1;
    aw_addr = {30'h0400_0000, off}; aw_size = size; aw_len = len; aw_burst = burst;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic send_w(input logic [3:0] strb, input logic last, input int stall);
    data_seq++;
    w_valid = 1; w_ready = 0; w_strb = strb; w_last = last;
    w_data = 32'hC0DE_0000 + data_seq;
    repeat (stall) @(negedge clk);
    w_ready = 1;
    @(negedge clk);
    w_valid = 0; w_ready = 0;
  endtask

  task automatic send_w_change(input logic [3:0] s0, input logic [3:0] s1,
                               input bit data_change, input logic last);
    data_seq++;
    w_valid = 1; w_ready = 0; w_strb = s0; w_last = last;
    w_data = 32'hC0DE_0000 + data_seq;
    @(negedge clk);
    w_strb = s1;
    if (data_change) w_data = w_data ^ 32'h0000_FF00;
    w_ready = 1;
    @(negedge clk);
    w_valid = 0; w_ready = 0;
  endtask

  task automatic close_case(input string tag);
    repeat (6) @(negedge clk);
    check(exp_code_q.size() == 0, tag, exp_code_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(err == 0 && err_code == 0, "R10 reset state", {err, err_code}, 0);

    // R1/R6: aligned full word incrementing, two beats
    send_aw(2'd0, 3'd2, 8'd1, 2'b01);
    send_w(4'b1111, 0, 0);
    send_w(4'b1111, 1, 2);
    close_case("R6 aligned word burst clean");

    // R2 sparse mask
    send_aw(2'd0, 3'd2, 8'd0, 2'b01);
    send_w(4'b1010, 1, 0);
    close_case("R2 sparse mask accepted");

    // R3 empty mask counts as beat
    send_aw(2'd0, 3'd2, 8'd1, 2'b01);
    send_w(4'b0000, 0, 0);
    send_w(4'b1111, 1, 0);
    send_aw(2'd0, 3'd2, 8'd0, 2'b01);
    send_w(4'b0000, 1, 1);
    close_case("R3 empty mask counted");

    // R1 byte at offset 2
    send_aw(2'd2, 3'd0, 8'd0, 2'b01);
    send_w(4'b0100, 1, 0);
    send_aw(2'd2, 3'd0, 8'd0, 2'b01);
    expect_err(3'd1, "R1 byte lane spill");
    send_w(4'b0110, 1, 0);
    close_case("R1 byte offset 2");

    // R1/R6 unaligned first beat of word burst
    send_aw(2'd1, 3'd2, 8'd1, 2'b01);
    expect_err(3'd1, "R1 unaligned first beat");
    send_w(4'b1111, 0, 0);
    send_w(4'b1111, 1, 0);
    close_case("R6 unaligned word burst");

    // R6 halfword incrementing walk
    send_aw(2'd2, 3'd1, 8'd2, 2'b01);
    send_w(4'b1100, 0, 0);
    send_w(4'b0011, 0, 0);
    send_w(4'b1100, 1, 0);
    send_aw(2'd2, 3'd1, 8'd2, 2'b01);
    send_w(4'b1100, 0, 0);
    expect_err(3'd1, "R6 incr second beat wrong lanes");
    send_w(4'b1100, 0, 0);
    send_w(4'b1100, 1, 0);
    close_case("R6 halfword incr");

    // R6 fixed burst repeats lanes
    send_aw(2'd2, 3'd1, 8'd2, 2'b00);
    send_w(4'b1100, 0, 0);
    send_w(4'b1100, 0, 0);
    send_w(4'b1100, 1, 0);
    send_aw(2'd2, 3'd1, 8'd1, 2'b00);
    send_w(4'b1100, 0, 0);
    expect_err(3'd1, "R6 fixed beat advanced");
    send_w(4'b0011, 1, 0);
    close_case("R6 fixed burst");

    // R7 last flag
    send_aw(2'd0, 3'd2, 8'd1, 2'b01);
    expect_err(3'd3, "R7 early last");
    send_w(4'b1111, 1, 0);
    send_w(4'b1111, 1, 0);
    send_aw(2'd0, 3'd2, 8'd0, 2'b01);
    expect_err(3'd3, "R7 missing last");
    send_w(4'b1111, 0, 0);
    close_case("R7 last flag");

    // R5 stability
    send_aw(2'd0, 3'd2, 8'd1, 2'b01);
    expect_err(3'd2, "R5 mask changed while waiting");
    send_w_change(4'b1111, 4'b0111, 0, 0);
    expect_err(3'd2, "R5 data changed while waiting");
    send_w_change(4'b1111, 4'b1111, 1, 1);
    close_case("R5 stability");

    // R4 mask ignored while valid low
    send_aw(2'd3, 3'd0, 8'd0, 2'b01);
    w_strb = 4'b1111; w_valid = 0;
    repeat (3) @(negedge clk);
    send_w(4'b1000, 1, 1);
    close_case("R4 mask ignored without handshake");

    // R9 early beats held until command
    send_w(4'b0001, 0, 0);
    send_w(4'b0001, 1, 0);
    repeat (2) @(negedge clk);
    send_aw(2'd0, 3'd0, 8'd1, 2'b00);
    close_case("R9 early beats checked later");

    // R9 overflow
    send_w(4'b1111, 0, 0);
    send_w(4'b1111, 0, 0);
    send_w(4'b1111, 0, 0);
    send_w(4'b1111, 1, 0);
    expect_err(3'd4, "R9 buffer overflow");
    send_w(4'b0001, 1, 0);
    repeat (2) @(negedge clk);
    send_aw(2'd0, 3'd2, 8'd3, 2'b01);
    close_case("R9 overflow drops beat");

    // R8 four queued commands in order
    send_aw(2'd0, 3'd0, 8'd0, 2'b01);
    send_aw(2'd3, 3'd0, 8'd0, 2'b01);
    send_aw(2'd2, 3'd1, 8'd0, 2'b01);
    send_aw(2'd0, 3'd2, 8'd0, 2'b01);
    send_w(4'b0001, 1, 0);
    send_w(4'b1000, 1, 0);
    send_w(4'b1100, 1, 0);
    send_w(4'b1111, 1, 0);
    close_case("R8 in-order matching");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule